// File: doc/BRIEF.md
# Two-Way Cache Controller with Run-Time Write and Allocation Policies

This block is a small data cache that sits between a processor word port and a single-word memory port. It has two ways and one least-recently-used bit per set. Each line keeps a tag, and each word in the line has its own valid bit and its own dirty bit. Three plain configuration pins set the policy at run time, and each can be changed independently of the others. The first selects write-back or write-through. The second selects whether a write miss claims a line. The third selects whether a read miss claims a line.

Addresses are word addresses with this layout: bits [1:0] give the word within the line, bits [4:2] give the set, and bits [11:5] give the tag. The processor holds `cpu_valid` high, with its address, data and direction unchanged, until it sees `cpu_ready`. `cpu_ready` is high for exactly one cycle, and it marks completion. Read data is valid in that cycle. The controller accepts a new request only while it is idle. Being busy is the only back-pressure it applies. On the memory side the controller raises `mem_valid` and holds its address, direction and data steady until the responder returns `mem_ready`. One word moves in the cycle where both are high. The responder may stall for any number of cycles.

Policy pins must not change while a request is in flight.

Top module: `pcache_ctrl`

## Requirements
- R1: After reset every line is invalid, `cpu_ready` and `mem_valid` are low, and the first read of any address misses.
- R2: A read whose tag matches and whose word is valid returns the stored word with `cpu_ready` high in the cycle after the second rising edge that sees the request, with no memory traffic.
- R3: A block occupies at most one way of its set. A matching valid tag is a hit and never creates a second copy.
- R4: On a miss that claims a line, a way with no valid words is used before any valid line is evicted. Way 0 wins when both ways are empty.
- R5: When both ways are valid, the least recently used way is the victim. A hit, a store and a completed fill each make their way the most recently used.
- R6: In write-back mode a write hit marks its word dirty and sends nothing to memory. When a line is evicted, only its dirty words are written, to the addresses of the old tag.
- R7: In write-through mode every write, whether it hits or misses, sends that single word to memory, and no word becomes dirty.
- R8: A write miss with write-allocate installs the new tag with only the written word valid, and nothing is fetched. A later read of another word in that line fetches only the words that are still invalid, and valid words are left untouched.
- R9: A write miss with write-no-allocate sends the word to memory only, and the cache is unchanged. A write hit still updates the cache under either setting.
- R10: A read miss with read-no-allocate returns the memory word and installs nothing, so repeating the read goes to memory again.
- R11: A read miss with read-allocate fetches the missing words of the line in ascending word order, then returns the requested word. The other words of the line then hit.
- R12: `cpu_ready` is high for exactly one cycle per request. While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr`, `mem_we` and `mem_wdata` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_write_back | input | 1 | 1 = write-back, 0 = write-through |
| cfg_write_alloc | input | 1 | 1 = a write miss claims a line |
| cfg_read_alloc | input | 1 | 1 = a read miss claims a line |
| cpu_valid | input | 1 | Processor request valid |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 12 | Word address |
| cpu_wdata | input | 32 | Write data |
| cpu_ready | output | 1 | One-cycle completion strobe |
| cpu_rdata | output | 32 | Read data, valid with cpu_ready |
| mem_valid | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = memory write |
| mem_addr | output | 12 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory transfer complete |
| mem_rdata | input | 32 | Memory read data, valid with mem_ready |

## Verification
A read hit is due two rising edges after the request is presented. Every other result depends on how long memory takes. For that reason the bench does not count cycles for those results. It waits for `cpu_ready`, samples one time unit after each rising edge, and only then compares the returned word with the expected value. It also compares how many memory reads and writes the responder counted during that request, which exposes evictions, fills and write-through traffic. Memory contents left by write-backs are read from the responder's model once the requests that cause them have completed. The one-cycle width of `cpu_ready` is checked on the edge after completion.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
  localparam int WAYS  = 2;
  localparam int WAY_W = $clog2(WAYS);

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_EVICT,
    ST_ALLOC,
    ST_FILL,
    ST_STORE,
    ST_MEMWR,
    ST_MEMRD,
    ST_RESP
  } pcc_state_t;
endpackage

// File: rtl/pcc_meta.sv
module pcc_meta
  import pcc_pkg::*;
#(
  parameter int SETS       = 8,
  parameter int LINE_WORDS = 4,
  parameter int TAG_W      = 7,
  localparam int IDX_W     = $clog2(SETS),
  localparam int OFF_W     = $clog2(LINE_WORDS)
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [IDX_W-1:0]                     set_i,
  input  logic [TAG_W-1:0]                     tag_i,
  output logic [WAYS-1:0]                      hit_o,
  output logic [WAYS-1:0][LINE_WORDS-1:0]      vld_o,
  output logic [WAYS-1:0][LINE_WORDS-1:0]      drt_o,
  output logic [WAYS-1:0][TAG_W-1:0]           tag_o,
  input  logic [WAY_W-1:0]                     up_way,
  input  logic [OFF_W-1:0]                     up_word,
  input  logic [TAG_W-1:0]                     up_tag,
  input  logic                                 install_en,
  input  logic                                 mark_en,
  input  logic                                 mark_dirty,
  input  logic                                 clean_en
);
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [TAG_W-1:0]      tag_q [SETS];
    logic [LINE_WORDS-1:0] vld_q [SETS];
    logic [LINE_WORDS-1:0] drt_q [SETS];
    logic                  sel;

    assign sel = (up_way == WAY_W'(w));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int s = 0; s < SETS; s++) begin
          tag_q[s] <= '0;
          vld_q[s] <= '0;
          drt_q[s] <= '0;
        end
      end else if (sel) begin
        if (install_en) begin
          tag_q[set_i] <= up_tag;
          vld_q[set_i] <= '0;
          drt_q[set_i] <= '0;
        end
        if (mark_en) begin
          vld_q[set_i][up_word] <= 1'b1;
          drt_q[set_i][up_word] <= mark_dirty;
        end
        if (clean_en) begin
          drt_q[set_i][up_word] <= 1'b0;
        end
      end
    end

    assign vld_o[w] = vld_q[set_i];
    assign drt_o[w] = drt_q[set_i];
    assign tag_o[w] = tag_q[set_i];
    assign hit_o[w] = (|vld_q[set_i]) && (tag_q[set_i] == tag_i);
  end

  // R3: a block never sits in two ways of one set
  a_r3_single_copy: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_o));
endmodule

// File: rtl/pcc_data.sv
module pcc_data
  import pcc_pkg::*;
#(
  parameter int SETS       = 8,
  parameter int LINE_WORDS = 4,
  parameter int DATA_W     = 32,
  localparam int IDX_W     = $clog2(SETS),
  localparam int OFF_W     = $clog2(LINE_WORDS),
  localparam int DEPTH     = SETS * LINE_WORDS
) (
  input  logic              clk,
  input  logic [WAY_W-1:0]  rd_way,
  input  logic [IDX_W-1:0]  rd_set,
  input  logic [OFF_W-1:0]  rd_word,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [WAY_W-1:0]  wr_way,
  input  logic [IDX_W-1:0]  wr_set,
  input  logic [OFF_W-1:0]  wr_word,
  input  logic [DATA_W-1:0] wr_data
);
  logic [DATA_W-1:0] way_rd [WAYS];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [DATA_W-1:0] store_q [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en && (wr_way == WAY_W'(w))) begin
        store_q[{wr_set, wr_word}] <= wr_data;
      end
    end

    assign way_rd[w] = store_q[{rd_set, rd_word}];
  end

  assign rd_data = way_rd[rd_way];
endmodule

// File: rtl/pcc_lru.sv
module pcc_lru
  import pcc_pkg::*;
#(
  parameter int SETS   = 8,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] set_i,
  output logic [WAY_W-1:0] lru_way_o,
  input  logic             touch_en,
  input  logic [WAY_W-1:0] touch_way
);
  // one bit per set naming the least recently used way
  logic [SETS-1:0] lru_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lru_q <= '0;
    end else if (touch_en) begin
      lru_q[set_i] <= ~touch_way;
    end
  end

  assign lru_way_o = lru_q[set_i];

  // R5: the touched way is no longer the eviction candidate
  a_r5_touch_moves_lru: assert property (@(posedge clk) disable iff (!rst_n)
    touch_en |=> (lru_way_o != $past(touch_way)));
endmodule

// File: rtl/pcache_ctrl.sv
module pcache_ctrl
  import pcc_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 32,
  parameter int SETS       = 8,
  parameter int LINE_WORDS = 4,
  localparam int OFF_W     = $clog2(LINE_WORDS),
  localparam int IDX_W     = $clog2(SETS),
  localparam int TAG_W     = ADDR_W - OFF_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_write_back,
  input  logic              cfg_write_alloc,
  input  logic              cfg_read_alloc,
  input  logic              cpu_valid,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_valid,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam logic [OFF_W-1:0] LAST_WORD = OFF_W'(LINE_WORDS - 1);

  pcc_state_t        state;
  logic [ADDR_W-1:0] req_addr;
  logic [DATA_W-1:0] req_wdata;
  logic              req_we;
  logic [WAY_W-1:0]  cur_way;
  logic [OFF_W-1:0]  wcnt;
  logic [DATA_W-1:0] resp_data;

  logic [OFF_W-1:0]  r_off;
  logic [IDX_W-1:0]  r_set;
  logic [TAG_W-1:0]  r_tag;
  assign r_off = req_addr[OFF_W-1:0];
  assign r_set = req_addr[OFF_W +: IDX_W];
  assign r_tag = req_addr[ADDR_W-1 -: TAG_W];

  // metadata, data and replacement state
  logic [WAYS-1:0]                 hit_vec;
  logic [WAYS-1:0][LINE_WORDS-1:0] vld_all, drt_all;
  logic [WAYS-1:0][TAG_W-1:0]      tag_all;
  logic [WAY_W-1:0]                lru_way;
  logic                            install_en, mark_en, mark_dirty, clean_en;
  logic [OFF_W-1:0]                up_word;
  logic                            touch_en;
  logic [WAY_W-1:0]                touch_way;
  logic                            d_we;
  logic [OFF_W-1:0]                d_word;
  logic [DATA_W-1:0]               d_wdata;
  logic [WAY_W-1:0]                dr_way;
  logic [OFF_W-1:0]                dr_word;
  logic [DATA_W-1:0]               d_rdata;

  pcc_meta #(.SETS(SETS), .LINE_WORDS(LINE_WORDS), .TAG_W(TAG_W)) u_meta (
    .clk(clk), .rst_n(rst_n), .set_i(r_set), .tag_i(r_tag),
    .hit_o(hit_vec), .vld_o(vld_all), .drt_o(drt_all), .tag_o(tag_all),
    .up_way(cur_way), .up_word(up_word), .up_tag(r_tag),
    .install_en(install_en), .mark_en(mark_en), .mark_dirty(mark_dirty),
    .clean_en(clean_en)
  );

  pcc_data #(.SETS(SETS), .LINE_WORDS(LINE_WORDS), .DATA_W(DATA_W)) u_data (
    .clk(clk), .rd_way(dr_way), .rd_set(r_set), .rd_word(dr_word),
    .rd_data(d_rdata), .wr_en(d_we), .wr_way(cur_way), .wr_set(r_set),
    .wr_word(d_word), .wr_data(d_wdata)
  );

  pcc_lru #(.SETS(SETS)) u_lru (
    .clk(clk), .rst_n(rst_n), .set_i(r_set), .lru_way_o(lru_way),
    .touch_en(touch_en), .touch_way(touch_way)
  );

  // hit way, line occupancy and victim choice
  logic             hit_any;
  logic [WAY_W-1:0] hit_way;
  logic [WAYS-1:0]  line_valid;
  logic [WAY_W-1:0] victim;

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_vec[w]) hit_way = WAY_W'(w);
      line_valid[w] = |vld_all[w];
    end
    victim = lru_way;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!line_valid[w]) victim = WAY_W'(w);
    end
  end
  assign hit_any = |hit_vec;

  logic [LINE_WORDS-1:0] cur_vld, cur_drt;
  logic [TAG_W-1:0]      cur_tag;
  assign cur_vld = vld_all[cur_way];
  assign cur_drt = drt_all[cur_way];
  assign cur_tag = tag_all[cur_way];

  assign dr_way  = (state == ST_LOOKUP) ? hit_way : cur_way;
  assign dr_word = (state == ST_EVICT) ? wcnt : r_off;

  // memory port drive, held steady by state and word counter
  always_comb begin
    mem_valid = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = req_addr;
    mem_wdata = req_wdata;
    unique case (state)
      ST_EVICT: begin
        mem_valid = cur_drt[wcnt];
        mem_we    = 1'b1;
        mem_addr  = {cur_tag, r_set, wcnt};
        mem_wdata = d_rdata;
      end
      ST_FILL: begin
        mem_valid = !cur_vld[wcnt];
        mem_addr  = {r_tag, r_set, wcnt};
      end
      ST_MEMWR: begin
        mem_valid = 1'b1;
        mem_we    = 1'b1;
      end
      ST_MEMRD: mem_valid = 1'b1;
      default: ;
    endcase
  end

  logic xfer, step_evict, step_fill, hit_word_ok;
  assign xfer        = mem_valid && mem_ready;
  assign step_evict  = !cur_drt[wcnt] || xfer;
  assign step_fill   = cur_vld[wcnt] || xfer;
  assign hit_word_ok = hit_any && vld_all[hit_way][r_off];

  // storage update strobes
  always_comb begin
    install_en = 1'b0;
    mark_en    = 1'b0;
    mark_dirty = 1'b0;
    clean_en   = 1'b0;
    touch_en   = 1'b0;
    touch_way  = cur_way;
    d_we       = 1'b0;
    d_word     = wcnt;
    d_wdata    = mem_rdata;
    up_word    = (state == ST_STORE) ? r_off : wcnt;
    unique case (state)
      ST_LOOKUP: begin
        if (!req_we && hit_word_ok) begin
          touch_en  = 1'b1;
          touch_way = hit_way;
        end
      end
      ST_EVICT: clean_en = xfer;
      ST_ALLOC: install_en = 1'b1;
      ST_FILL: begin
        if (xfer) begin
          d_we    = 1'b1;
          mark_en = 1'b1;
        end
        touch_en = step_fill && (wcnt == LAST_WORD);
      end
      ST_STORE: begin
        d_we       = 1'b1;
        d_word     = r_off;
        d_wdata    = req_wdata;
        mark_en    = 1'b1;
        mark_dirty = cfg_write_back;
        touch_en   = 1'b1;
      end
      default: ;
    endcase
  end

  // sequencing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      req_addr  <= '0;
      req_wdata <= '0;
      req_we    <= 1'b0;
      cur_way   <= '0;
      wcnt      <= '0;
      resp_data <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (cpu_valid) begin
            req_addr  <= cpu_addr;
            req_wdata <= cpu_wdata;
            req_we    <= cpu_we;
            state     <= ST_LOOKUP;
          end
        end
        ST_LOOKUP: begin
          wcnt <= '0;
          if (req_we) begin
            if (hit_any) begin
              cur_way <= hit_way;
              state   <= ST_STORE;
            end else if (cfg_write_alloc) begin
              cur_way <= victim;
              state   <= ST_EVICT;
            end else begin
              state <= ST_MEMWR;
            end
          end else if (hit_word_ok) begin
            resp_data <= d_rdata;
            state     <= ST_RESP;
          end else if (cfg_read_alloc) begin
            cur_way <= hit_any ? hit_way : victim;
            state   <= hit_any ? ST_FILL : ST_EVICT;
          end else begin
            state <= ST_MEMRD;
          end
        end
        ST_EVICT: begin
          if (step_evict) begin
            wcnt <= wcnt + 1'b1;
            if (wcnt == LAST_WORD) state <= ST_ALLOC;
          end
        end
        ST_ALLOC: begin
          wcnt  <= '0;
          state <= req_we ? ST_STORE : ST_FILL;
        end
        ST_FILL: begin
          if (xfer && (wcnt == r_off)) resp_data <= mem_rdata;
          if (step_fill) begin
            wcnt <= wcnt + 1'b1;
            if (wcnt == LAST_WORD) state <= ST_RESP;
          end
        end
        ST_STORE: state <= cfg_write_back ? ST_RESP : ST_MEMWR;
        ST_MEMWR: if (xfer) state <= ST_RESP;
        ST_MEMRD: begin
          if (xfer) begin
            resp_data <= mem_rdata;
            state     <= ST_RESP;
          end
        end
        ST_RESP: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cpu_ready = (state == ST_RESP);
  assign cpu_rdata = resp_data;

  // R12: completion is a single-cycle strobe
  a_r12_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !cpu_ready);

  // R12: a waiting memory request holds its fields
  a_r12_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=>
      (mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R4: with an empty way present, the chosen victim is empty
  a_r4_empty_first: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_EVICT && !(&line_valid) && $past(state) == ST_LOOKUP) |->
      !line_valid[cur_way]);

  // R7: write-through mode completes a write only after a memory write
  a_r7_wt_sends: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STORE && !cfg_write_back) |=> (state == ST_MEMWR));
endmodule

// File: tb/tb_pcache_ctrl.sv
`timescale 1ns/1ps
module tb_pcache_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_write_back = 1'b1, cfg_write_alloc = 1'b1, cfg_read_alloc = 1'b1;
  logic        cpu_valid = 1'b0, cpu_we = 1'b0;
  logic [11:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic        cpu_ready;
  logic [31:0] cpu_rdata;
  logic        mem_valid, mem_we;
  logic [11:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #5 clk = ~clk;

  pcache_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cfg_write_back(cfg_write_back),
    .cfg_write_alloc(cfg_write_alloc), .cfg_read_alloc(cfg_read_alloc),
    .cpu_valid(cpu_valid), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata)
  );

  // behavioural memory responder, two-cycle stall per word
  logic [31:0] model [4096];
  logic        written [4096];
  int          rd_cnt = 0, wr_cnt = 0, lat_cnt = 0;

  function automatic logic [31:0] mem_word(input logic [11:0] a);
    return written[a] === 1'b1 ? model[a] : {20'hC0DE0, a};
  endfunction

  always @(posedge clk) begin
    mem_ready <= 1'b0;
    if (mem_valid && !mem_ready) begin
      if (lat_cnt == 2) begin
        lat_cnt   <= 0;
        mem_ready <= 1'b1;
        if (mem_we) begin
          model[mem_addr]   <= mem_wdata;
          written[mem_addr] <= 1'b1;
          wr_cnt            <= wr_cnt + 1;
        end else begin
          mem_rdata <= mem_word(mem_addr);
          rd_cnt    <= rd_cnt + 1;
        end
      end else begin
        lat_cnt <= lat_cnt + 1;
      end
    end
  end

  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000 && !done) begin
      failures = failures + 1;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input int rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL R%0d %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic run_req(input logic we, input logic [11:0] a, input logic [31:0] wd,
                         output logic [31:0] rd, output int lat, output logic pulse_ok);
    @(negedge clk);
    cpu_valid = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    lat = 0;
    do begin
      @(posedge clk); #1;
      lat++;
    end while (!cpu_ready && lat < 400);
    rd = cpu_rdata;
    @(posedge clk); #1;
    pulse_ok = !cpu_ready;
    cpu_valid = 1'b0;
  endtask

  typedef struct packed {
    logic        wb, wal, ral, we;
    logic [11:0] addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic [3:0]  nrd;
    logic [3:0]  nwr;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 28;
  // set = addr[4:2], tag = addr[11:5], word = addr[1:0]
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b1,1'b1,1'b0,12'h005,32'h0,       32'hC0DE0005,4'd4,4'd0,4'd11}, // R1 R11 cold miss fills line
    '{1'b1,1'b1,1'b1,1'b0,12'h007,32'h0,       32'hC0DE0007,4'd0,4'd0,4'd2},  // R2 hit
    '{1'b1,1'b1,1'b1,1'b1,12'h006,32'h11111111,32'h0,       4'd0,4'd0,4'd6},  // R6 write-back hit
    '{1'b1,1'b1,1'b1,1'b0,12'h006,32'h0,       32'h11111111,4'd0,4'd0,4'd6},
    '{1'b1,1'b1,1'b1,1'b0,12'h025,32'h0,       32'hC0DE0025,4'd4,4'd0,4'd4},  // R4 empty way used
    '{1'b1,1'b1,1'b1,1'b0,12'h004,32'h0,       32'hC0DE0004,4'd0,4'd0,4'd3},  // R3 still one copy, hit
    '{1'b1,1'b1,1'b1,1'b0,12'h045,32'h0,       32'hC0DE0045,4'd4,4'd0,4'd5},  // R5 evict clean LRU way
    '{1'b1,1'b1,1'b1,1'b0,12'h024,32'h0,       32'hC0DE0024,4'd4,4'd1,4'd6},  // R6 one dirty word out
    '{1'b1,1'b1,1'b1,1'b0,12'h006,32'h0,       32'h11111111,4'd4,4'd0,4'd6},
    '{1'b0,1'b1,1'b1,1'b1,12'h025,32'h22222222,32'h0,       4'd0,4'd1,4'd7},  // R7 write-through hit
    '{1'b0,1'b1,1'b1,1'b0,12'h025,32'h0,       32'h22222222,4'd0,4'd0,4'd7},
    '{1'b0,1'b1,1'b1,1'b1,12'h00C,32'h33333333,32'h0,       4'd0,4'd1,4'd8},  // R8 allocate one word
    '{1'b0,1'b1,1'b1,1'b0,12'h00C,32'h0,       32'h33333333,4'd0,4'd0,4'd8},
    '{1'b0,1'b1,1'b1,1'b0,12'h00E,32'h0,       32'hC0DE000E,4'd3,4'd0,4'd8},  // R8 fetch only invalid words
    '{1'b0,1'b1,1'b1,1'b0,12'h00C,32'h0,       32'h33333333,4'd0,4'd0,4'd8},
    '{1'b0,1'b1,1'b1,1'b0,12'h00D,32'h0,       32'hC0DE000D,4'd0,4'd0,4'd11},
    '{1'b0,1'b0,1'b0,1'b1,12'h100,32'h44444444,32'h0,       4'd0,4'd1,4'd9},  // R9 write-around
    '{1'b0,1'b0,1'b0,1'b0,12'h100,32'h0,       32'h44444444,4'd1,4'd0,4'd10}, // R10 not installed
    '{1'b0,1'b0,1'b0,1'b0,12'h100,32'h0,       32'h44444444,4'd1,4'd0,4'd10},
    '{1'b0,1'b0,1'b0,1'b1,12'h00F,32'h55555555,32'h0,       4'd0,4'd1,4'd9},  // R9 hit still updates
    '{1'b0,1'b0,1'b0,1'b0,12'h00F,32'h0,       32'h55555555,4'd0,4'd0,4'd9},
    '{1'b1,1'b0,1'b1,1'b1,12'h200,32'h66666666,32'h0,       4'd0,4'd1,4'd9},
    '{1'b1,1'b0,1'b1,1'b0,12'h200,32'h0,       32'h66666666,4'd4,4'd0,4'd11},
    '{1'b1,1'b0,1'b1,1'b0,12'h201,32'h0,       32'hC0DE0201,4'd0,4'd0,4'd11},
    '{1'b1,1'b1,1'b1,1'b1,12'h300,32'h77777777,32'h0,       4'd0,4'd0,4'd6},  // R6 allocate dirty
    '{1'b1,1'b1,1'b1,1'b0,12'h300,32'h0,       32'h77777777,4'd0,4'd0,4'd6},
    '{1'b1,1'b1,1'b1,1'b0,12'h320,32'h0,       32'hC0DE0320,4'd4,4'd0,4'd5},  // R5 LRU way 0 goes
    '{1'b1,1'b1,1'b1,1'b0,12'h340,32'h0,       32'hC0DE0340,4'd4,4'd1,4'd6}
  };

  initial begin
    logic [31:0] rd;
    int          lat, r0, w0;
    logic        pulse_ok;

    repeat (3) @(posedge clk);
    #1;
    // R1: reset state at the ports
    chk(cpu_ready == 1'b0, 1, "cpu_ready in reset", 32'(cpu_ready), 32'h0);
    chk(mem_valid == 1'b0, 1, "mem_valid in reset", 32'(mem_valid), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      cfg_write_back  = VECS[i].wb;
      cfg_write_alloc = VECS[i].wal;
      cfg_read_alloc  = VECS[i].ral;
      r0 = rd_cnt;
      w0 = wr_cnt;
      run_req(VECS[i].we, VECS[i].addr, VECS[i].wdata, rd, lat, pulse_ok);
      chk(lat < 400, int'(VECS[i].rq), $sformatf("vec %0d completion", i), 32'(lat), 32'd0);
      chk(rd_cnt - r0 == int'(VECS[i].nrd), int'(VECS[i].rq),
          $sformatf("vec %0d memory reads", i), 32'(rd_cnt - r0), 32'(VECS[i].nrd));
      chk(wr_cnt - w0 == int'(VECS[i].nwr), int'(VECS[i].rq),
          $sformatf("vec %0d memory writes", i), 32'(wr_cnt - w0), 32'(VECS[i].nwr));
      if (!VECS[i].we)
        chk(rd == VECS[i].rdata, int'(VECS[i].rq),
            $sformatf("vec %0d read data", i), rd, VECS[i].rdata);
    end

    // R6: written-back dirty words landed at the old tag's addresses
    chk(mem_word(12'h006) == 32'h11111111, 6, "writeback of 0x006", mem_word(12'h006), 32'h11111111);
    chk(mem_word(12'h300) == 32'h77777777, 6, "writeback of 0x300", mem_word(12'h300), 32'h77777777);
    // R7: write-through values in memory
    chk(mem_word(12'h025) == 32'h22222222, 7, "write-through 0x025", mem_word(12'h025), 32'h22222222);
    chk(mem_word(12'h00C) == 32'h33333333, 7, "write-through 0x00C", mem_word(12'h00C), 32'h33333333);
    // R9: write-around value in memory
    chk(mem_word(12'h100) == 32'h44444444, 9, "write-around 0x100", mem_word(12'h100), 32'h44444444);

    // R2 and R12: hit latency and single-cycle completion strobe
    r0 = rd_cnt;
    run_req(1'b0, 12'h341, 32'h0, rd, lat, pulse_ok);
    chk(lat == 2, 2, "read hit latency", 32'(lat), 32'd2);
    chk(rd == 32'hC0DE0341, 2, "read hit data", rd, 32'hC0DE0341);
    chk(rd_cnt == r0, 2, "read hit memory reads", 32'(rd_cnt - r0), 32'd0);
    chk(pulse_ok, 12, "cpu_ready width", 32'(!pulse_ok), 32'd0);

    // R1: a second reset empties the cache
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(cpu_ready == 1'b0 && mem_valid == 1'b0, 1, "ports in second reset",
        {cpu_ready, mem_valid}, 32'h0);
    rst_n = 1'b1;
    r0 = rd_cnt;
    run_req(1'b0, 12'h341, 32'h0, rd, lat, pulse_ok);
    chk(rd_cnt - r0 == 4, 1, "miss after reset reads", 32'(rd_cnt - r0), 32'd4);
    chk(rd == 32'hC0DE0341, 1, "miss after reset data", rd, 32'hC0DE0341);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule